// File: doc/BRIEF.md
# Preemptive Priority Interrupt Arbiter

This block arbitrates a parameterized set of level-sensitive interrupt request lines for a single processor. Every line carries a programmable priority and a fixed vector number equal to its line index. The arbiter tracks the processor's current execution priority. It raises a registered pending indication with a vector whenever an active request outranks that level. When the processor acknowledges, the arbiter moves the current priority up to the accepted level.

The level that was interrupted is saved on a last-in, first-out stack. Each end-of-interrupt write pops one saved level and makes it current again, so nested service routines unwind in order. Any request still held above the restored level is then taken in the usual way. Within the highest eligible level, the lowest vector number wins. The order in which the requests arrived plays no part.

Top module: `intc_arbiter`

## Requirements
- R1: After reset, `irq_pend_o` is 0, `cur_prio_o` is 0 and `eoi_err_o` is 0.
- R2: Line i has priority `prio_cfg_i[i*4 +: 4]` and vector number i. A request asserted before a clock edge whose priority is strictly above `cur_prio_o` sets `irq_pend_o` at that edge, with `irq_vec_o` = i. The vector number does not matter. A request at or below `cur_prio_o` is held and never sets `irq_pend_o`.
- R3: Among eligible requests at the same highest priority, the one with the lowest vector number is presented.
- R4: A line configured at priority 0 is never presented.
- R5: An `irq_ack_i` pulse while `irq_pend_o` is 1 has two effects at the next edge: `cur_prio_o` becomes the presented request's priority, and `irq_pend_o` drops to 0. An `irq_ack_i` pulse while `irq_pend_o` is 0 changes nothing.
- R6: Each acknowledge saves the prior current priority on a stack. An `eoi_wr_i` pulse restores the most recently saved value at the next edge, so nested levels unwind in reverse order.
- R7: An `eoi_wr_i` pulse with nothing saved leaves `cur_prio_o` at 0 and sets `eoi_err_o`. Once set, `eoi_err_o` stays 1 until reset.
- R8: Once an end-of-interrupt write has lowered `cur_prio_o`, any held request above the restored level is presented one cycle later. The same highest-priority, lowest-vector rule applies.
- R9: While `irq_pend_o` is 1 and unacknowledged, `irq_vec_o` stays stable. The one exception is a newly eligible request of strictly higher priority, which replaces it. An equal-priority request with a lower vector does not replace it.
- R10: When `irq_ack_i` and `eoi_wr_i` fall in the same cycle, the pop is applied first and the restored level is what gets saved. `cur_prio_o` becomes the accepted priority, and a later end-of-interrupt write returns to the restored level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | NUM_IRQ | Level-sensitive request lines |
| prio_cfg_i | input | NUM_IRQ*PRIO_W | Per-line priority, line i at bits [i*PRIO_W +: PRIO_W] |
| irq_ack_i | input | 1 | Single-cycle acknowledge of the presented vector |
| eoi_wr_i | input | 1 | Single-cycle end-of-interrupt write strobe |
| irq_pend_o | output | 1 | Registered interrupt-pending indication |
| irq_vec_o | output | VEC_W | Vector number of the presented request |
| cur_prio_o | output | PRIO_W | Current execution priority |
| eoi_err_o | output | 1 | Sticky flag: end-of-interrupt write with empty stack |

## Verification
The bench nests three service levels, with a low-priority request pending below each of them. This separates strict priority comparison from a greater-or-equal comparison, and it shows that held requests surface only after the right pop. Two requests at the same level are raised in reverse vector order. This exposes any arbitration that favours arrival time or the higher index. A stream of same-level and then higher-level arrivals is applied while a vector is pending and unacknowledged, which distinguishes replacement from simple re-selection. A simultaneous acknowledge and end-of-interrupt write, followed by one further pop, tells pop-then-push apart from the opposite order.

// File: rtl/intc_arb_pkg.sv
package intc_arb_pkg;
  localparam int unsigned PRIO_W_DEF  = 4;
  localparam int unsigned NUM_IRQ_DEF = 8;

  // stack depth needed to hold every level strictly below the top one
  function automatic int unsigned stack_depth(input int unsigned prio_w);
    return (1 << prio_w) - 1;
  endfunction
endpackage

// File: rtl/intc_arb_select.sv
module intc_arb_select #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned VEC_W   = 3
) (
  input  logic [NUM_IRQ-1:0]        req_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         thresh_i,
  output logic                      valid_o,
  output logic [VEC_W-1:0]          vec_o,
  output logic [PRIO_W-1:0]         prio_o
);
  logic [PRIO_W-1:0] lvl [NUM_IRQ];

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_unpack
    assign lvl[g] = prio_i[g*PRIO_W +: PRIO_W];
  end

  // ascending scan with strict compare: first (lowest) index keeps a tie
  always_comb begin
    valid_o = 1'b0;
    vec_o   = '0;
    prio_o  = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (req_i[i] && (lvl[i] > thresh_i) && (!valid_o || (lvl[i] > prio_o))) begin
        valid_o = 1'b1;
        vec_o   = VEC_W'(i);
        prio_o  = lvl[i];
      end
    end
  end
endmodule

// File: rtl/intc_arb_stack.sv
module intc_arb_stack #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DEPTH = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] push_data_i,
  output logic [WIDTH-1:0] top_o,
  output logic             empty_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d, after_pop;
  logic             full;

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign top_o   = empty_o ? '0 : mem_q[cnt_q - CNT_W'(1)];

  // pop is resolved first, push lands on the slot the pop freed
  always_comb begin
    after_pop = (pop_i && !empty_o) ? cnt_q - CNT_W'(1) : cnt_q;
    cnt_d     = push_i ? after_pop + CNT_W'(1) : after_pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (push_i) mem_q[after_pop] <= push_data_i;
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |-> !full);

  p_pop_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_arb_pkg::*;
#(
  parameter int unsigned NUM_IRQ = NUM_IRQ_DEF,
  parameter int unsigned PRIO_W  = PRIO_W_DEF
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [NUM_IRQ-1:0]                        irq_req_i,
  input  logic [NUM_IRQ*PRIO_W-1:0]                 prio_cfg_i,
  input  logic                                      irq_ack_i,
  input  logic                                      eoi_wr_i,
  output logic                                      irq_pend_o,
  output logic [((NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1)-1:0] irq_vec_o,
  output logic [PRIO_W-1:0]                         cur_prio_o,
  output logic                                      eoi_err_o
);
  localparam int unsigned VEC_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int unsigned DEPTH = stack_depth(PRIO_W);

  logic              sel_valid;
  logic [VEC_W-1:0]  sel_vec;
  logic [PRIO_W-1:0] sel_prio;

  logic              pend_q, pend_d;
  logic [VEC_W-1:0]  vec_q, vec_d;
  logic [PRIO_W-1:0] vprio_q, vprio_d;
  logic [PRIO_W-1:0] cur_q, cur_d, base_lvl;
  logic              err_q, err_d;
  logic              take, stk_push, stk_pop, stk_empty;
  logic [PRIO_W-1:0] stk_top;

  intc_arb_select #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_sel (
    .req_i    (irq_req_i),
    .prio_i   (prio_cfg_i),
    .thresh_i (cur_q),
    .valid_o  (sel_valid),
    .vec_o    (sel_vec),
    .prio_o   (sel_prio)
  );

  intc_arb_stack #(.WIDTH(PRIO_W), .DEPTH(DEPTH)) u_stk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (stk_push),
    .pop_i       (stk_pop),
    .push_data_i (base_lvl),
    .top_o       (stk_top),
    .empty_o     (stk_empty)
  );

  assign take = irq_ack_i && pend_q;

  // level bookkeeping: pop first, then push of the restored level
  always_comb begin
    err_d    = err_q;
    stk_pop  = eoi_wr_i;
    stk_push = take;
    base_lvl = cur_q;
    if (eoi_wr_i) begin
      base_lvl = stk_top;
      if (stk_empty) err_d = 1'b1;
    end
    cur_d = take ? vprio_q : base_lvl;
  end

  // presented-request register
  always_comb begin
    pend_d  = pend_q;
    vec_d   = vec_q;
    vprio_d = vprio_q;
    if (take) begin
      pend_d = 1'b0;
    end else if (!pend_q || (sel_valid && (sel_prio > vprio_q))) begin
      pend_d  = sel_valid;
      vec_d   = sel_vec;
      vprio_d = sel_prio;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      vec_q   <= '0;
      vprio_q <= '0;
      cur_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      vec_q   <= vec_d;
      vprio_q <= vprio_d;
      cur_q   <= cur_d;
      err_q   <= err_d;
    end
  end

  assign irq_pend_o = pend_q;
  assign irq_vec_o  = vec_q;
  assign cur_prio_o = cur_q;
  assign eoi_err_o  = err_q;

  p_pend_above_cur_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend_o |-> (vprio_q > cur_prio_o));

  p_ack_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend_o && irq_ack_i) |=> (!irq_pend_o && (cur_prio_o > $past(cur_prio_o))));

  p_ack_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_pend_o && irq_ack_i && !eoi_wr_i) |=> $stable(cur_prio_o));

  p_pend_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend_o && !irq_ack_i) |=> irq_pend_o);

  p_vec_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend_o && !irq_ack_i && !(sel_valid && (sel_prio > vprio_q))) |=> $stable(irq_vec_o));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_err_o |=> eoi_err_o);

  p_empty_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr_i && stk_empty) |=> eoi_err_o);
endmodule

// File: tb/tb_intc_arbiter.sv
module tb_intc_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req;
  logic [N*PW-1:0] cfg;
  logic          ack, eoi;
  logic          pend;
  logic [2:0]    vec;
  logic [PW-1:0] cur;
  logic          err;

  typedef struct {
    logic       pend;
    logic [2:0] vec;
    logic [3:0] cur;
    logic       err;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_arbiter #(.NUM_IRQ(N), .PRIO_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req_i(req), .prio_cfg_i(cfg),
    .irq_ack_i(ack), .eoi_wr_i(eoi), .irq_pend_o(pend), .irq_vec_o(vec),
    .cur_prio_o(cur), .eoi_err_o(err)
  );

  // monitor: compares at the falling edge, well away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (pend !== e.pend || (e.pend && vec !== e.vec) || cur !== e.cur || err !== e.err) begin
        n_fail++;
        $display("FAIL %s: got pend=%0b vec=%0d cur=%0d err=%0b, expected pend=%0b vec=%0d cur=%0d err=%0b",
                 e.tag, pend, vec, cur, err, e.pend, e.vec, e.cur, e.err);
      end
    end
  end

  // driver step: one clock edge, then queue what must be visible after it
  task automatic step(input logic p, input int v, input int c, input logic er, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    e.pend = p; e.vec = 3'(v); e.cur = 4'(c); e.err = er; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic set_prio(input int line, input int p);
    cfg[line*PW +: PW] = PW'(p);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = '0; cfg = '0; ack = 1'b0; eoi = 1'b0;
    set_prio(0, 2); set_prio(1, 1); set_prio(2, 3); set_prio(3, 3);
    set_prio(4, 4); set_prio(5, 0); set_prio(6, 4); set_prio(7, 6);
    step(0, 0, 0, 0, "R1 reset held");
    rst_n = 1'b1;
    step(0, 0, 0, 0, "R1 after release");

    ack = 1'b1; step(0, 0, 0, 0, "R5 ack without pending ignored"); ack = 1'b0;

    req[5] = 1'b1; step(0, 0, 0, 0, "R4 priority 0 line never pending");
    step(0, 0, 0, 0, "R4 still not pending");

    req[1] = 1'b1; step(1, 1, 0, 0, "R2 prio1 above 0 pending");
    ack = 1'b1; step(0, 1, 1, 0, "R5 ack raises to 1"); ack = 1'b0;
    step(0, 0, 1, 0, "R2 equal priority does not preempt");
    req[1] = 1'b0;

    req[4] = 1'b1; step(1, 4, 1, 0, "R2 prio4 preempts level 1");
    ack = 1'b1; step(0, 4, 4, 0, "R5 ack raises to 4"); ack = 1'b0;
    req[4] = 1'b0;
    req[3] = 1'b1; step(0, 0, 4, 0, "R2 lower request held");
    req[2] = 1'b1; step(0, 0, 4, 0, "R2 second lower request held");

    eoi = 1'b1; step(0, 0, 1, 0, "R6 eoi restores 1"); eoi = 1'b0;
    step(1, 2, 1, 0, "R3 R8 tie goes to lowest vector 2");
    ack = 1'b1; step(0, 2, 3, 0, "R5 ack raises to 3"); ack = 1'b0;
    req[2] = 1'b0;
    step(0, 0, 3, 0, "R2 equal level 3 request held");
    eoi = 1'b1; step(0, 0, 1, 0, "R6 eoi back to 1"); eoi = 1'b0;
    step(1, 3, 1, 0, "R8 held vector 3 taken next");
    ack = 1'b1; step(0, 3, 3, 0, "R5 ack vector 3"); ack = 1'b0;
    req[3] = 1'b0;
    eoi = 1'b1; step(0, 0, 1, 0, "R6 unwind to 1"); eoi = 1'b0;
    eoi = 1'b1; step(0, 0, 0, 0, "R6 unwind to 0"); eoi = 1'b0;
    eoi = 1'b1; step(0, 0, 0, 1, "R7 empty eoi sets error"); eoi = 1'b0;
    step(0, 0, 0, 1, "R7 error sticky");

    req[5] = 1'b0;
    req[6] = 1'b1; step(1, 6, 0, 1, "R9 vector 6 presented");
    req[4] = 1'b1; step(1, 6, 0, 1, "R9 equal prio lower vector no replace");
    req[7] = 1'b1; step(1, 7, 0, 1, "R9 higher prio replaces");
    ack = 1'b1; step(0, 7, 6, 1, "R5 ack raises to 6"); ack = 1'b0;
    req[7] = 1'b0; req[6] = 1'b0;
    step(0, 0, 6, 1, "R2 prio4 held under 6");

    eoi = 1'b1; step(0, 0, 0, 1, "R6 eoi restores 0"); eoi = 1'b0;
    step(1, 4, 0, 1, "R8 vector 4 after restore");
    ack = 1'b1; step(0, 4, 4, 1, "R5 ack raises to 4"); ack = 1'b0;
    req[4] = 1'b0;
    req[7] = 1'b1; step(1, 7, 4, 1, "R2 prio6 preempts 4");
    ack = 1'b1; eoi = 1'b1; step(0, 7, 6, 1, "R10 ack with eoi gives 6");
    ack = 1'b0; eoi = 1'b0;
    req[7] = 1'b0;
    eoi = 1'b1; step(0, 0, 0, 1, "R10 next eoi returns to restored 0"); eoi = 1'b0;
    step(0, 0, 0, 1, "R1 idle at end");

    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule